// File: doc/BRIEF.md
# Vector Destination Writeback Merge Sequencer

This block walks the elements of one vector destination register group, one element per clock, and decides for each one what gets written back. For every element it presents the element index to the surrounding datapath, takes back the freshly computed result, the prior destination contents, the element's mask bit and a fault flag, and produces a write enable and a merged write value. Elements inside the active length that are enabled take the new result. Elements that the mask switches off are written back with their prior value. Elements at or past the active length are written as zero.

The walk starts at the restart index supplied with the start pulse and ends at the last element of the register group. The group size is the number of elements in one register scaled by a power-of-two group multiplier. A fault reported on an enabled element stops the walk without writing that element. It raises a trap and leaves the restart index pointing at the faulting element, so that a second start with that index completes the instruction. A normal finish clears the restart index to zero.

Top module: `vec_wb_merge`

## Requirements
- R1: After reset, busy_o, wr_en_o, done_o and trap_o are 0 and vstart_o is 0.
- R2: A start_i pulse seen while idle makes busy_o 1 in the next cycle with elem_idx_o equal to the captured vstart_i. The index then rises by exactly one per cycle. start_i seen while busy is ignored.
- R3: An enabled body element (vstart ≤ index < vl, and either mask_en_i = 0 or mask_bit_i = 1) gives wr_en_o = 1 and wr_data_o = new_elem_i.
- R4: A masked-off body element (index < vl, mask_en_i = 1, mask_bit_i = 0) gives wr_en_o = 1 and wr_data_o = old_elem_i, and a fault_i on it is ignored.
- R5: A tail element (vl ≤ index < group size) gives wr_en_o = 1 and wr_data_o = 0, and a fault_i on it is ignored.
- R6: The group size is (VLEN/ELEM_W) << lmul_log2_i, which is 8, 16, 32 or 64 elements with the default parameters. done_o is 1 in the cycle that presents index group size − 1. A vl above the group size acts as if it were equal to the group size.
- R7: No index below the captured vstart is ever presented. When vstart ≥ group size, the walk lasts one cycle with wr_en_o = 0 and done_o = 1.
- R8: After a normal finish (done_o = 1, trap_o = 0), busy_o is 0 and vstart_o is 0 in the next cycle.
- R9: fault_i on an enabled body element gives trap_o = 1, done_o = 1 and wr_en_o = 0 in that cycle. In the next cycle busy_o is 0 and vstart_o equals the faulting index.
- R10: While busy, vstart_o holds the vstart_i value captured at the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse for one instruction's writeback walk |
| vl_i | input | IDX_W | Active vector length, captured at start |
| vstart_i | input | IDX_W | First element to process, captured at start |
| lmul_log2_i | input | LMUL_W | log2 of register-group multiplier, captured at start |
| mask_en_i | input | 1 | 1 = instruction is masked, captured at start |
| elem_idx_o | output | IDX_W | Index of the element handled this cycle |
| busy_o | output | 1 | Walk in progress |
| new_elem_i | input | ELEM_W | New result for elem_idx_o |
| old_elem_i | input | ELEM_W | Prior destination value for elem_idx_o |
| mask_bit_i | input | 1 | Mask bit for elem_idx_o |
| fault_i | input | 1 | Fault reported for elem_idx_o |
| wr_en_o | output | 1 | Write the destination element this cycle |
| wr_data_o | output | ELEM_W | Merged value to write |
| trap_o | output | 1 | Fault accepted this cycle |
| done_o | output | 1 | Last cycle of the walk |
| vstart_o | output | IDX_W | Restart index state |

## Verification
The first element appears in the cycle after the clock edge that samples start_i. From then on, the write enable, merged data, trap and done for an element are due in the same cycle that its index is shown, because they are combinational from that index and the datapath inputs. The restart index after a finish or a trap is due one cycle after done_o. The bench drives stimulus and samples every output at the falling edge, and a behavioural model predicts each cycle's element from the captured length, restart index, group size, mask pattern and fault position. Starts made while busy, restarts after a trap, zero length, an oversized length and a restart index past the group are exercised.

// File: rtl/vwm_pkg.sv
package vwm_pkg;
   typedef enum logic [1:0] {
      EL_ACTIVE = 2'd0,
      EL_KEEP   = 2'd1,
      EL_TAIL   = 2'd2,
      EL_BEYOND = 2'd3
   } elem_cls_e;
endpackage

// File: rtl/vwm_sequencer.sv
module vwm_sequencer #(
   parameter int IDX_W      = 7,
   parameter int LMUL_W     = 2,
   parameter int BASE_ELEMS = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [IDX_W-1:0]  vl_i,
   input  logic [IDX_W-1:0]  vstart_i,
   input  logic [LMUL_W-1:0] lmul_i,
   input  logic              mask_en_i,
   input  logic              finish_i,
   output logic              busy_o,
   output logic [IDX_W-1:0]  idx_o,
   output logic [IDX_W-1:0]  cap_o,
   output logic [IDX_W-1:0]  vl_o,
   output logic              mask_en_o,
   output logic              last_o
);
   localparam logic [IDX_W-1:0] BASE_CNT = IDX_W'(BASE_ELEMS);

   logic              busy_q;
   logic [IDX_W-1:0]  idx_q;
   logic [IDX_W-1:0]  cap_q;
   logic [IDX_W-1:0]  vl_q;
   logic              men_q;
   logic              accept;

   assign accept = start_i && !busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         idx_q  <= '0;
         cap_q  <= BASE_CNT;
         vl_q   <= '0;
         men_q  <= 1'b0;
      end else if (accept) begin
         busy_q <= 1'b1;
         idx_q  <= vstart_i;
         cap_q  <= BASE_CNT << lmul_i;
         vl_q   <= vl_i;
         men_q  <= mask_en_i;
      end else if (busy_q) begin
         if (finish_i) begin
            busy_q <= 1'b0;
         end else begin
            idx_q <= idx_q + 1'b1;
         end
      end
   end

   assign busy_o    = busy_q;
   assign idx_o     = idx_q;
   assign cap_o     = cap_q;
   assign vl_o      = vl_q;
   assign mask_en_o = men_q;
   assign last_o    = (idx_q >= cap_q - 1'b1);
endmodule

// File: rtl/vwm_policy.sv
module vwm_policy
   import vwm_pkg::*;
#(
   parameter int IDX_W             = 7,
   parameter int ELEM_W            = 16,
   parameter bit MASKED_WRITES_OLD = 1'b1
) (
   input  logic              busy_i,
   input  logic [IDX_W-1:0]  idx_i,
   input  logic [IDX_W-1:0]  vl_i,
   input  logic [IDX_W-1:0]  cap_i,
   input  logic              mask_en_i,
   input  logic              mask_bit_i,
   input  logic [ELEM_W-1:0] new_i,
   input  logic [ELEM_W-1:0] old_i,
   input  logic              fault_i,
   output elem_cls_e         cls_o,
   output logic              wr_en_o,
   output logic [ELEM_W-1:0] wr_data_o,
   output logic              fault_take_o
);
   elem_cls_e   cls;
   logic        keep_en;
   logic [ELEM_W-1:0] keep_data;

   always_comb begin
      if (idx_i >= cap_i) begin
         cls = EL_BEYOND;
      end else if (idx_i >= vl_i) begin
         cls = EL_TAIL;
      end else if (mask_en_i && !mask_bit_i) begin
         cls = EL_KEEP;
      end else begin
         cls = EL_ACTIVE;
      end
   end

   generate
      if (MASKED_WRITES_OLD) begin : g_keep_write
         assign keep_en   = 1'b1;
         assign keep_data = old_i;
      end else begin : g_keep_skip
         logic unused_old;
         assign unused_old = ^old_i;
         assign keep_en    = 1'b0;
         assign keep_data  = '0;
      end
   endgenerate

   assign fault_take_o = busy_i && (cls == EL_ACTIVE) && fault_i;

   always_comb begin
      wr_en_o   = 1'b0;
      wr_data_o = '0;
      if (busy_i) begin
         unique case (cls)
            EL_ACTIVE: begin
               wr_en_o   = !fault_i;
               wr_data_o = new_i;
            end
            EL_KEEP: begin
               wr_en_o   = keep_en;
               wr_data_o = keep_data;
            end
            EL_TAIL: begin
               wr_en_o   = 1'b1;
               wr_data_o = '0;
            end
            default: begin
               wr_en_o   = 1'b0;
               wr_data_o = '0;
            end
         endcase
      end
   end

   assign cls_o = cls;
endmodule

// File: rtl/vec_wb_merge.sv
module vec_wb_merge
   import vwm_pkg::*;
#(
   parameter int ELEM_W            = 16,
   parameter int VLEN              = 128,
   parameter int MAX_LMUL_LOG2     = 3,
   parameter bit MASKED_WRITES_OLD = 1'b1,
   localparam int BASE_ELEMS       = VLEN / ELEM_W,
   localparam int MAX_ELEMS        = BASE_ELEMS << MAX_LMUL_LOG2,
   localparam int IDX_W            = $clog2(MAX_ELEMS + 1),
   localparam int LMUL_W           = (MAX_LMUL_LOG2 > 0) ? $clog2(MAX_LMUL_LOG2 + 1) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [IDX_W-1:0]  vl_i,
   input  logic [IDX_W-1:0]  vstart_i,
   input  logic [LMUL_W-1:0] lmul_log2_i,
   input  logic              mask_en_i,
   output logic [IDX_W-1:0]  elem_idx_o,
   output logic              busy_o,
   input  logic [ELEM_W-1:0] new_elem_i,
   input  logic [ELEM_W-1:0] old_elem_i,
   input  logic              mask_bit_i,
   input  logic              fault_i,
   output logic              wr_en_o,
   output logic [ELEM_W-1:0] wr_data_o,
   output logic              trap_o,
   output logic              done_o,
   output logic [IDX_W-1:0]  vstart_o
);
   generate
      if (ELEM_W < 1 || VLEN < ELEM_W) begin : g_bad_width
         $error("vec_wb_merge: VLEN must be at least ELEM_W");
      end
      if (VLEN % ELEM_W != 0) begin : g_bad_ratio
         $error("vec_wb_merge: VLEN must be a multiple of ELEM_W");
      end
      if (MAX_LMUL_LOG2 < 0 || MAX_LMUL_LOG2 > 3) begin : g_bad_lmul
         $error("vec_wb_merge: MAX_LMUL_LOG2 must be 0..3");
      end
   endgenerate

   logic              seq_busy;
   logic [IDX_W-1:0]  seq_idx;
   logic [IDX_W-1:0]  seq_cap;
   logic [IDX_W-1:0]  seq_vl;
   logic              seq_men;
   logic              seq_last;
   logic              fault_take;
   logic              finish;
   elem_cls_e         elem_cls;
   logic [IDX_W-1:0]  vstart_q;

   assign finish = seq_busy && (seq_last || fault_take);

   vwm_sequencer #(
      .IDX_W      (IDX_W),
      .LMUL_W     (LMUL_W),
      .BASE_ELEMS (BASE_ELEMS)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (start_i),
      .vl_i      (vl_i),
      .vstart_i  (vstart_i),
      .lmul_i    (lmul_log2_i),
      .mask_en_i (mask_en_i),
      .finish_i  (finish),
      .busy_o    (seq_busy),
      .idx_o     (seq_idx),
      .cap_o     (seq_cap),
      .vl_o      (seq_vl),
      .mask_en_o (seq_men),
      .last_o    (seq_last)
   );

   vwm_policy #(
      .IDX_W             (IDX_W),
      .ELEM_W            (ELEM_W),
      .MASKED_WRITES_OLD (MASKED_WRITES_OLD)
   ) u_pol (
      .busy_i       (seq_busy),
      .idx_i        (seq_idx),
      .vl_i         (seq_vl),
      .cap_i        (seq_cap),
      .mask_en_i    (seq_men),
      .mask_bit_i   (mask_bit_i),
      .new_i        (new_elem_i),
      .old_i        (old_elem_i),
      .fault_i      (fault_i),
      .cls_o        (elem_cls),
      .wr_en_o      (wr_en_o),
      .wr_data_o    (wr_data_o),
      .fault_take_o (fault_take)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vstart_q <= '0;
      end else if (start_i && !seq_busy) begin
         vstart_q <= vstart_i;
      end else if (fault_take) begin
         vstart_q <= seq_idx;
      end else if (finish) begin
         vstart_q <= '0;
      end
   end

   assign elem_idx_o = seq_idx;
   assign busy_o     = seq_busy;
   assign trap_o     = fault_take;
   assign done_o     = finish;
   assign vstart_o   = vstart_q;
endmodule

// File: rtl/vwm_checker.sv
module vwm_checker
   import vwm_pkg::*;
#(
   parameter int IDX_W  = 7,
   parameter int ELEM_W = 16,
   parameter bit KEEP_W = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic [IDX_W-1:0]  idx,
   input logic [IDX_W-1:0]  cap,
   input logic [IDX_W-1:0]  vl,
   input logic              men,
   input logic              mask_bit,
   input logic              fault,
   input logic [ELEM_W-1:0] new_elem,
   input logic [ELEM_W-1:0] old_elem,
   input logic              wr_en,
   input logic [ELEM_W-1:0] wr_data,
   input logic              trap,
   input logic              done,
   input logic [IDX_W-1:0]  vstart,
   input elem_cls_e         cls
);
   a_r1_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!wr_en && !done && !trap));

   a_r2_index_step: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> (busy && idx == $past(idx) + 1'b1));

   a_r3_active_new: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && idx < cap && idx < vl && (!men || mask_bit) && !fault)
      |-> (wr_en && wr_data == new_elem));

   a_r4_masked_keep: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && idx < cap && idx < vl && men && !mask_bit)
      |-> (!trap && wr_en == KEEP_W && (!wr_en || wr_data == old_elem)));

   a_r5_tail_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && idx < cap && idx >= vl) |-> (wr_en && wr_data == '0 && !trap));

   a_r6_last_done: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && idx == cap - 1'b1) |-> done);

   a_r7_not_below: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (idx >= vstart));

   a_r7_beyond_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cls == EL_BEYOND) |-> (!wr_en && done));

   a_r8_clear_vstart: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !trap) |=> (!busy && vstart == '0));

   a_r9_trap_hold: assert property (@(posedge clk) disable iff (!rst_n)
      trap |=> (!busy && vstart == $past(idx)));

   a_r9_trap_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      trap |-> (done && !wr_en));

   a_r10_vstart_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> $stable(vstart));
endmodule

bind vec_wb_merge vwm_checker #(
   .IDX_W  (IDX_W),
   .ELEM_W (ELEM_W),
   .KEEP_W (MASKED_WRITES_OLD)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .busy     (busy_o),
   .idx      (elem_idx_o),
   .cap      (seq_cap),
   .vl       (seq_vl),
   .men      (seq_men),
   .mask_bit (mask_bit_i),
   .fault    (fault_i),
   .new_elem (new_elem_i),
   .old_elem (old_elem_i),
   .wr_en    (wr_en_o),
   .wr_data  (wr_data_o),
   .trap     (trap_o),
   .done     (done_o),
   .vstart   (vstart_o),
   .cls      (elem_cls)
);

// File: tb/vec_wb_merge_bench.sv
module vec_wb_merge_bench;
   localparam int CLK_PERIOD = 10;
   localparam int IDX_W      = 7;
   localparam int ELEM_W     = 16;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start_i = 1'b0;
   logic [IDX_W-1:0]  vl_i = '0;
   logic [IDX_W-1:0]  vstart_i = '0;
   logic [1:0]        lmul_log2_i = '0;
   logic              mask_en_i = 1'b0;
   logic [IDX_W-1:0]  elem_idx_o;
   logic              busy_o;
   logic [ELEM_W-1:0] new_elem_i;
   logic [ELEM_W-1:0] old_elem_i;
   logic              mask_bit_i;
   logic              fault_i;
   logic              wr_en_o;
   logic [ELEM_W-1:0] wr_data_o;
   logic              trap_o;
   logic              done_o;
   logic [IDX_W-1:0]  vstart_o;

   logic [63:0] mask_pat = '0;
   int          fault_at = -1;
   int          checks = 0;
   int          fails  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   assign new_elem_i = 16'hA000 + 16'(elem_idx_o);
   assign old_elem_i = 16'h5000 + 16'(elem_idx_o);
   assign mask_bit_i = (elem_idx_o < 64) ? mask_pat[elem_idx_o[5:0]] : 1'b0;
   assign fault_i    = (int'(elem_idx_o) == fault_at);

   vec_wb_merge u_vec_wb_merge (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .vl_i(vl_i),
      .vstart_i(vstart_i), .lmul_log2_i(lmul_log2_i), .mask_en_i(mask_en_i),
      .elem_idx_o(elem_idx_o), .busy_o(busy_o), .new_elem_i(new_elem_i),
      .old_elem_i(old_elem_i), .mask_bit_i(mask_bit_i), .fault_i(fault_i),
      .wr_en_o(wr_en_o), .wr_data_o(wr_data_o), .trap_o(trap_o),
      .done_o(done_o), .vstart_o(vstart_o)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic summary;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   // One instruction walk with a behavioural per-element model.
   task automatic run(input int vl, input int vs, input int lm, input bit men,
                      input logic [63:0] mp, input int fidx, input bit glitch);
      int  cap;
      int  e;
      bit  fin;
      int  exp_vs;
      cap = 8 << lm;
      @(negedge clk);
      start_i = 1'b1; vl_i = IDX_W'(vl); vstart_i = IDX_W'(vs);
      lmul_log2_i = 2'(lm); mask_en_i = men; mask_pat = mp; fault_at = fidx;
      @(negedge clk);
      start_i = 1'b0;
      e = vs; fin = 1'b0; exp_vs = 0;
      while (!fin) begin
         bit body, act, trp, dn, we;
         int data;
         body = (e < vl) && (e < cap);
         act  = body && (!men || ((e < 64) && mp[e]));
         trp  = act && (e == fidx);
         dn   = (e >= cap - 1) || trp;
         if (e >= cap)       begin we = 0; data = 0; end
         else if (trp)       begin we = 0; data = 0; end
         else if (act)       begin we = 1; data = 'hA000 + e; end
         else if (body)      begin we = 1; data = 'h5000 + e; end
         else                begin we = 1; data = 0; end
         chk("R2", "busy", int'(busy_o), 1);
         chk("R7", "index", int'(elem_idx_o), e);
         chk("R10", "vstart during run", int'(vstart_o), vs);
         chk(act ? "R3" : (body ? "R4" : (e < cap ? "R5" : "R7")), "wr_en", int'(wr_en_o), int'(we));
         if (we) chk(act ? "R3" : (body ? "R4" : "R5"), "wr_data", int'(wr_data_o), data);
         chk("R9", "trap", int'(trap_o), int'(trp));
         chk("R6", "done", int'(done_o), int'(dn));
         if (trp) exp_vs = e;
         if (glitch && e == vs) begin
            start_i = 1'b1; vstart_i = IDX_W'(vs + 1);
         end
         if (dn) fin = 1'b1;
         else begin
            @(negedge clk);
            start_i = 1'b0;
            e++;
         end
      end
      @(negedge clk);
      start_i = 1'b0;
      chk(exp_vs != 0 ? "R9" : "R8", "busy after end", int'(busy_o), 0);
      chk(exp_vs != 0 ? "R9" : "R8", "vstart after end", int'(vstart_o), exp_vs);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected finish");
      summary();
      $finish;
   end

   initial begin
      repeat (2) @(negedge clk);
      chk("R1", "busy at reset", int'(busy_o), 0);
      chk("R1", "wr_en at reset", int'(wr_en_o), 0);
      chk("R1", "done at reset", int'(done_o), 0);
      chk("R1", "trap at reset", int'(trap_o), 0);
      chk("R1", "vstart at reset", int'(vstart_o), 0);
      rst_n = 1'b1;
      // R3/R5: unmasked, short length, tail zeroed
      run(5, 0, 0, 1'b0, 64'h0, -1, 1'b0);
      // R4: alternating mask over full group
      run(8, 0, 0, 1'b1, 64'hAAAA_AAAA_AAAA_AAAA, -1, 1'b0);
      // R2/R7: group of 16, restart at 3, start pulse while busy ignored
      run(10, 3, 1, 1'b1, 64'h0000_0000_0000_F0F3, -1, 1'b1);
      // R9: fault on an enabled element, then resume from the trap index
      run(12, 0, 1, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 6, 1'b0);
      run(12, int'(vstart_o), 1, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, -1, 1'b0);
      // R5: fault on a tail element ignored
      run(4, 0, 0, 1'b0, 64'h0, 5, 1'b0);
      // R4: fault on a masked-off element ignored
      run(8, 0, 0, 1'b1, 64'hFFFF_FFFF_FFFF_FFFB, 2, 1'b0);
      // R6: length larger than the group
      run(64, 0, 0, 1'b0, 64'h0, -1, 1'b0);
      // R7: restart index beyond the group
      run(5, 10, 0, 1'b0, 64'h0, -1, 1'b0);
      // R5: zero length, everything is tail
      run(0, 0, 0, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, -1, 1'b0);
      // R6: largest group
      run(40, 2, 3, 1'b1, 64'h1234_5678_9ABC_DEF0, -1, 1'b0);
      // R9: fault at the last element of the group
      run(16, 0, 1, 1'b0, 64'h0, 15, 1'b0);
      run(16, 15, 1, 1'b0, 64'h0, -1, 1'b0);
      summary();
      $finish;
   end
endmodule